// File: doc/BRIEF.md
# Two-Layer Gamma and Common-Voltage Code Registers with Output Clamp

This block keeps the digital codes for eight gamma reference channels and one common-voltage channel of a display reference driver. Each channel has two register layers. Writes from the control bus land in a staging layer. The code presented to the converters sits in a separate output layer. The output layer is reloaded only when a transfer happens. A transfer comes from a dedicated update strobe or from a bus write whose data bit 15 is set. A load from non-volatile storage (acquire) fills both layers of one channel at once.

The common-voltage channel has a programmable upper bound and lower bound. The bound check happens at the moment of transfer, not at the moment of writing. So the bounds and the code can be programmed in either order, and the staging layer always holds the raw code for saving to storage. When the upper bound is below the lower bound, the bounds are disregarded. Readback returns the code that actually reached the output layer, zero-extended to a 16-bit bus word.

Top module: `gamma_latch_bank`

## Requirements
- R1: After reset, all nine output codes and staging codes are 0x200, the upper bound is 0x3FF and the lower bound is 0x000.
- R2: A bus write to address 0..7 (gamma) or 8 (common) with data bit 15 clear changes only the staging layer; the output codes stay unchanged.
- R3: A pulse on `upd_all` loads all nine output codes from the staging layer together, visible the cycle after the strobe; a write in the same cycle is included.
- R4: A bus write with data bit 15 set stores its value and then transfers all nine channels in the same cycle, whatever its address.
- R5: On transfer, a common-voltage code above the upper bound becomes the upper bound.
- R6: On transfer, a common-voltage code below the lower bound becomes the lower bound.
- R7: When the upper bound is less than the lower bound, the common-voltage code is transferred unchanged.
- R8: `rd_data` returns the output code for addresses 0..8, the upper bound at 9, the lower bound at 10 and zero elsewhere; bits 15:10 are always zero.
- R9: `com_raw` shows the unclamped staging code of the common-voltage channel.
- R10: Only data bits 9:0 of a bus write are stored; bits 14:10 are dropped.
- R11: An acquire to address 0..8 loads both layers of that channel in one cycle (clamped for common) and wins over a bus write to the same address in that cycle; an acquire to 9 or 10 loads that bound.
- R12: The bounds used at a transfer are those in force after the same cycle's bound writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write valid |
| wr_addr | input | 5 | Bus write address |
| wr_data | input | 16 | Bus write word; bit 15 requests a transfer |
| upd_all | input | 1 | Global transfer strobe |
| acq_en | input | 1 | Acquire load valid |
| acq_addr | input | 5 | Acquire target address |
| acq_data | input | 10 | Code read from storage |
| rd_addr | input | 5 | Readback address |
| rd_data | output | 16 | Readback word (combinational) |
| gamma_out | output | 80 | Eight gamma output codes, channel n at bits 10n+9:10n |
| com_out | output | 10 | Common-voltage output code (clamped) |
| com_raw | output | 10 | Common-voltage staging code (unclamped) |

## Verification
Directed sequences set a common-voltage code above, below and between the bounds, then with the bounds inverted. This separates a clamp that checks each bound on its own from one that first tests that the bounds are ordered. Other directed cases put bus writes, acquires and transfer strobes in the same cycle and on the same address. These expose mistakes in priority and in the ordering between staging and output. A seeded random phase mixes writes to every address, including unused ones and ones with high junk bits, with random bounds and random transfers. After every cycle all outputs and one readback address are compared against a reference model in the bench.

// File: rtl/gl_pkg.sv
package gl_pkg;

    localparam int BUS_W    = 16;
    localparam int XFER_BIT = 15;

    typedef enum logic [2:0] {
        SEL_GAMMA,
        SEL_COM,
        SEL_HI,
        SEL_LO,
        SEL_NONE
    } gl_sel_e;

    function automatic gl_sel_e gl_decode(input int unsigned addr, input int unsigned n_gamma);
        if (addr < n_gamma)          return SEL_GAMMA;
        else if (addr == n_gamma)     return SEL_COM;
        else if (addr == n_gamma + 1) return SEL_HI;
        else if (addr == n_gamma + 2) return SEL_LO;
        else                          return SEL_NONE;
    endfunction

endpackage

// File: rtl/gl_clamp.sv
module gl_clamp #(
    parameter int DATA_W = 10
) (
    input  logic              en,
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    output logic [DATA_W-1:0] res
);

    logic ordered;

    always_comb begin
        ordered = (lim_hi >= lim_lo);
        res     = val;
        if (en && ordered) begin
            if (val > lim_hi)      res = lim_hi;
            else if (val < lim_lo) res = lim_lo;
        end
    end

endmodule

// File: rtl/gl_cell.sv
module gl_cell #(
    parameter int          DATA_W    = 10,
    parameter logic [DATA_W-1:0] RESET_VAL = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clamp_en,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              acq_hit,
    input  logic [DATA_W-1:0] acq_val,
    input  logic              xfer,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    output logic [DATA_W-1:0] stage_o,
    output logic [DATA_W-1:0] out_o
);

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] outv;
    } cell_t;

    cell_t             st_d, st_q;
    logic [DATA_W-1:0] shaped;

    gl_clamp #(.DATA_W(DATA_W)) u_clamp (
        .en     (clamp_en),
        .val    (st_d.stage),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .res    (shaped)
    );

    always_comb begin
        st_d.stage = st_q.stage;
        if (acq_hit)     st_d.stage = acq_val;
        else if (wr_hit) st_d.stage = wr_val;
        st_d.outv = st_q.outv;
        if (acq_hit || xfer) st_d.outv = shaped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage <= RESET_VAL;
            st_q.outv  <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.stage;
    assign out_o   = st_q.outv;

    // R2: no transfer and no acquire means the output layer keeps its code
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer || acq_hit) |=> $stable(st_q.outv));

    // R5: ordered bounds cap the transferred code from above
    assert_clamp_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && (xfer || acq_hit) && lim_hi >= lim_lo) |=> (st_q.outv <= $past(lim_hi)));

    // R6: ordered bounds hold the transferred code up from below
    assert_clamp_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && (xfer || acq_hit) && lim_hi >= lim_lo) |=> (st_q.outv >= $past(lim_lo)));

    // R7: inverted bounds pass the staged code through untouched
    assert_inverted_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && xfer && !acq_hit && !wr_hit && lim_hi < lim_lo) |=> (st_q.outv == $past(st_q.stage)));

    // R11: an acquire leaves both layers of an unclamped channel equal
    assert_acq_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_hit && !clamp_en) |=> (st_q.outv == st_q.stage));

endmodule

// File: rtl/gl_limits.sv
module gl_limits #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic              hi_acq,
    input  logic              lo_acq,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [DATA_W-1:0] acq_val,
    output logic [DATA_W-1:0] hi_nx,
    output logic [DATA_W-1:0] lo_nx,
    output logic [DATA_W-1:0] hi_q_o,
    output logic [DATA_W-1:0] lo_q_o
);

    localparam logic [DATA_W-1:0] HI_RST = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] LO_RST = '0;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } lim_t;

    lim_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (hi_acq)     lim_d.hi = acq_val;
        else if (hi_wr) lim_d.hi = wr_val;
        if (lo_acq)     lim_d.lo = acq_val;
        else if (lo_wr) lim_d.lo = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q.hi <= HI_RST;
            lim_q.lo <= LO_RST;
        end else begin
            lim_q <= lim_d;
        end
    end

    assign hi_nx  = lim_d.hi;
    assign lo_nx  = lim_d.lo;
    assign hi_q_o = lim_q.hi;
    assign lo_q_o = lim_q.lo;

    // R11: an acquire aimed at the upper bound lands in it
    assert_hi_acq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hi_acq |=> (lim_q.hi == $past(acq_val)));

    // R12: untouched bounds keep their values
    assert_lim_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_wr || hi_acq || lo_wr || lo_acq) |=> ($stable(lim_q.hi) && $stable(lim_q.lo)));

endmodule

// File: rtl/gl_readmux.sv
module gl_readmux
    import gl_pkg::*;
#(
    parameter int NUM_CH = 9,
    parameter int DATA_W = 10,
    parameter int ADDR_W = 5
) (
    input  logic [NUM_CH*DATA_W-1:0] codes,
    input  logic [DATA_W-1:0]        lim_hi,
    input  logic [DATA_W-1:0]        lim_lo,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BUS_W-1:0]         rd_data
);

    localparam int N_GAMMA = NUM_CH - 1;

    gl_sel_e sel;

    always_comb begin
        sel     = gl_decode(int'(rd_addr), N_GAMMA);
        rd_data = '0;
        unique case (sel)
            SEL_GAMMA, SEL_COM: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (int'(rd_addr) == i) rd_data[DATA_W-1:0] = codes[i*DATA_W +: DATA_W];
                end
            end
            SEL_HI:   rd_data[DATA_W-1:0] = lim_hi;
            SEL_LO:   rd_data[DATA_W-1:0] = lim_lo;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gamma_latch_bank.sv
module gamma_latch_bank
    import gl_pkg::*;
#(
    parameter int NUM_GAMMA = 8,
    parameter int DATA_W    = 10,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BUS_W-1:0]            wr_data,
    input  logic                        upd_all,
    input  logic                        acq_en,
    input  logic [ADDR_W-1:0]           acq_addr,
    input  logic [DATA_W-1:0]           acq_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BUS_W-1:0]            rd_data,
    output logic [NUM_GAMMA*DATA_W-1:0] gamma_out,
    output logic [DATA_W-1:0]           com_out,
    output logic [DATA_W-1:0]           com_raw
);

    localparam int NUM_CH  = NUM_GAMMA + 1;
    localparam int COM_IDX = NUM_GAMMA;
    localparam int HI_IDX  = NUM_GAMMA + 1;
    localparam int LO_IDX  = NUM_GAMMA + 2;
    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0]        wr_val;
    logic                     xfer;
    logic [DATA_W-1:0]        hi_nx, lo_nx, hi_q, lo_q;
    logic [NUM_CH*DATA_W-1:0] out_codes;
    logic [NUM_CH*DATA_W-1:0] stage_codes;
    logic                     unused_hi_bits;

    assign wr_val         = wr_data[DATA_W-1:0];
    assign unused_hi_bits = ^wr_data[XFER_BIT-1:DATA_W];
    assign xfer           = upd_all | (wr_en & wr_data[XFER_BIT]);

    gl_limits #(.DATA_W(DATA_W)) u_limits (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_wr   (wr_en  && (wr_addr  == ADDR_W'(HI_IDX))),
        .lo_wr   (wr_en  && (wr_addr  == ADDR_W'(LO_IDX))),
        .hi_acq  (acq_en && (acq_addr == ADDR_W'(HI_IDX))),
        .lo_acq  (acq_en && (acq_addr == ADDR_W'(LO_IDX))),
        .wr_val  (wr_val),
        .acq_val (acq_data),
        .hi_nx   (hi_nx),
        .lo_nx   (lo_nx),
        .hi_q_o  (hi_q),
        .lo_q_o  (lo_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic acq_hit, wr_hit;
        assign acq_hit = acq_en && (acq_addr == ADDR_W'(c));
        assign wr_hit  = wr_en && (wr_addr == ADDR_W'(c)) && !acq_hit;

        gl_cell #(.DATA_W(DATA_W), .RESET_VAL(MID_CODE)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clamp_en (c == COM_IDX),
            .wr_hit   (wr_hit),
            .wr_val   (wr_val),
            .acq_hit  (acq_hit),
            .acq_val  (acq_data),
            .xfer     (xfer),
            .lim_hi   (hi_nx),
            .lim_lo   (lo_nx),
            .stage_o  (stage_codes[c*DATA_W +: DATA_W]),
            .out_o    (out_codes[c*DATA_W +: DATA_W])
        );
    end

    gl_readmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .codes   (out_codes),
        .lim_hi  (hi_q),
        .lim_lo  (lo_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign gamma_out = out_codes[NUM_GAMMA*DATA_W-1:0];
    assign com_out   = out_codes[COM_IDX*DATA_W +: DATA_W];
    assign com_raw   = stage_codes[COM_IDX*DATA_W +: DATA_W];

    // R8: readback never carries bits above the code width
    assert_rd_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:DATA_W] == '0);

    // R4: a write flagged with the transfer bit leaves the common output equal to its clamp of the staging code when bounds allow it
    assert_flag_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[XFER_BIT] && !acq_en && (hi_nx >= lo_nx)) |=>
            ((com_out == com_raw) || (com_out == hi_q) || (com_out == lo_q)));

endmodule

// File: tb/gamma_latch_bank_test.sv
`timescale 1ns/1ps
module gamma_latch_bank_test;

    localparam int NG = 8;
    localparam int DW = 10;
    localparam int AW = 5;
    localparam int NC = NG + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, upd_all, acq_en;
    logic [AW-1:0]     wr_addr, acq_addr, rd_addr;
    logic [15:0]       wr_data;
    logic [DW-1:0]     acq_data;
    logic [15:0]       rd_data;
    logic [NG*DW-1:0]  gamma_out;
    logic [DW-1:0]     com_out, com_raw;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [DW-1:0] stage_m [NC];
    logic [DW-1:0] out_m   [NC];
    logic [DW-1:0] hi_m, lo_m;

    always #2.5 clk = ~clk;

    gamma_latch_bank #(.NUM_GAMMA(NG), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .upd_all(upd_all), .acq_en(acq_en), .acq_addr(acq_addr), .acq_data(acq_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .gamma_out(gamma_out),
        .com_out(com_out), .com_raw(com_raw)
    );

    function automatic logic [DW-1:0] clampf(logic [DW-1:0] v, logic [DW-1:0] h, logic [DW-1:0] l);
        if (h < l) return v;
        if (v > h) return h;
        if (v < l) return l;
        return v;
    endfunction

    function automatic logic [15:0] rd_model(int a);
        if (a < NC) return {6'b0, out_m[a]};
        if (a == NC) return {6'b0, hi_m};
        if (a == NC + 1) return {6'b0, lo_m};
        return 16'h0;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            stage_m[c] = 10'h200;
            out_m[c]   = 10'h200;
        end
        hi_m = 10'h3FF;
        lo_m = 10'h000;
    endtask

    task automatic model_step(bit we, int wa, logic [15:0] wd, bit up, bit ae, int aa, logic [DW-1:0] ad);
        bit xf;
        xf = up || (we && wd[15]);
        if (ae && aa < NC) stage_m[aa] = ad;
        if (we && wa < NC && !(ae && aa == wa)) stage_m[wa] = wd[DW-1:0];
        if (ae && aa == NC) hi_m = ad;
        else if (we && wa == NC) hi_m = wd[DW-1:0];
        if (ae && aa == NC + 1) lo_m = ad;
        else if (we && wa == NC + 1) lo_m = wd[DW-1:0];
        for (int c = 0; c < NC; c++) begin
            if (xf || (ae && aa == c))
                out_m[c] = (c == NG) ? clampf(stage_m[c], hi_m, lo_m) : stage_m[c];
        end
    endtask

    task automatic check_all(string tag, int ra);
        for (int c = 0; c < NG; c++) chk(tag, {6'b0, gamma_out[c*DW +: DW]}, {6'b0, out_m[c]});
        chk(tag, {6'b0, com_out}, {6'b0, out_m[NG]});
        chk({tag, "/R9"}, {6'b0, com_raw}, {6'b0, stage_m[NG]});
        rd_addr = AW'(ra);
        #1;
        chk({tag, "/R8"}, rd_data, rd_model(ra));
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(string tag, bit we, int wa, logic [15:0] wd, bit up, bit ae, int aa, logic [DW-1:0] ad, int ra);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd; upd_all = up;
        acq_en = ae; acq_addr = AW'(aa); acq_data = ad;
        @(posedge clk);
        model_step(we, wa, wd, up, ae, aa, ad);
        @(negedge clk);
        wr_en = 0; upd_all = 0; acq_en = 0;
        check_all(tag, ra);
    endtask

    task automatic wr(string tag, int a, logic [15:0] d, int ra);
        step(tag, 1, a, d, 0, 0, 0, '0, ra);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1F2E3D);
        rst_n = 0; wr_en = 0; upd_all = 0; acq_en = 0;
        wr_addr = '0; wr_data = '0; acq_addr = '0; acq_data = '0; rd_addr = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_all("R1", 9);
        rd_addr = 10; #1; chk("R1 lo", rd_data, 16'h0000);

        // R2 staging only
        wr("R2", 3, 16'h0123, 3);
        wr("R2", 8, 16'h0345, 8);
        chk("R2 com_raw", {6'b0, com_raw}, 16'h0345);
        chk("R2 com_out", {6'b0, com_out}, 16'h0200);

        // R3 global strobe, with a same-cycle write included
        step("R3", 1, 0, 16'h0011, 1, 0, 0, '0, 0);
        chk("R3 ch0", {6'b0, gamma_out[9:0]}, 16'h0011);
        chk("R3 ch3", {6'b0, gamma_out[39:30]}, 16'h0123);

        // R4 flagged write
        wr("R4", 5, 16'h8077, 5);
        chk("R4 ch5", {6'b0, gamma_out[59:50]}, 16'h0077);

        // R5 upper clamp
        wr("R5", 9, 16'h0300, 9);
        wr("R5", 8, 16'h03A0, 8);
        step("R5", 0, 0, 16'h0, 1, 0, 0, '0, 8);
        chk("R5 com", {6'b0, com_out}, 16'h0300);
        chk("R9 raw", {6'b0, com_raw}, 16'h03A0);
        rd_addr = 8; #1; chk("R8 clamped rd", rd_data, 16'h0300);

        // R6 lower clamp
        wr("R6", 10, 16'h0100, 10);
        wr("R6", 8, 16'h8050, 8);
        chk("R6 com", {6'b0, com_out}, 16'h0100);

        // R7 inverted bounds
        wr("R7", 9, 16'h0080, 9);
        wr("R7", 8, 16'h83F0, 8);
        chk("R7 com", {6'b0, com_out}, 16'h03F0);

        // R10 junk upper bits dropped
        wr("R10", 2, 16'h7C55, 2);
        step("R10", 0, 0, 16'h0, 1, 0, 0, '0, 2);
        chk("R10 ch2", {6'b0, gamma_out[29:20]}, 16'h0055);

        // R11 acquire beats same-address write; loads both layers; bound acquire
        step("R11", 1, 4, 16'h0111, 0, 1, 4, 10'h2AA, 4);
        chk("R11 ch4", {6'b0, gamma_out[49:40]}, 16'h02AA);
        step("R11", 0, 0, 16'h0, 0, 1, 9, 10'h3FF, 9);
        step("R11", 0, 0, 16'h0, 0, 1, 10, 10'h000, 10);
        step("R11", 0, 0, 16'h0, 0, 1, 8, 10'h155, 8);
        chk("R11 com", {6'b0, com_out}, 16'h0155);

        // R12 bound written with the flag uses its new value
        wr("R12", 8, 16'h0390, 8);
        wr("R12", 9, 16'h8200, 8);
        chk("R12 com", {6'b0, com_out}, 16'h0200);

        // unused address: nothing moves
        wr("R8", 13, 16'h0123, 13);

        // random phase
        for (int i = 0; i < 600; i++) begin
            bit            we, up, ae;
            int            wa, aa, ra;
            logic [15:0]   wd;
            logic [DW-1:0] ad;
            we = ($urandom % 2) == 0;
            wa = $urandom % 13;
            wd = 16'($urandom);
            wd[15] = ($urandom % 8) == 0;
            up = ($urandom % 6) == 0;
            ae = ($urandom % 5) == 0;
            aa = $urandom % 13;
            ad = DW'($urandom);
            ra = $urandom % 16;
            step("R3/R5/R6/R7/R11 random", we, wa, wd, up, ae, aa, ad, ra);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule